// File: doc/BRIEF.md
# Binary and Packed-Decimal Add/Subtract Unit

This block is a purely combinational arithmetic slice that adds with carry or subtracts with borrow on two operands of `DIGITS` packed decimal digits (8 bits by default). A mode input selects the number system. In binary mode the operands are plain unsigned or two's-complement words. In decimal mode each 4-bit nibble is one decimal digit, and the unit corrects each digit inside the add or subtract path. The result is therefore valid packed BCD with no further step.

Subtraction treats the carry as an inverted borrow. A carry-in of 1 means nothing is borrowed, and a carry-out of 1 means the subtraction needed no borrow. The sign, overflow and zero outputs only have meaning in binary mode. In decimal mode a validity output goes low and those three outputs are held at 0. Operands that contain nibbles above 9 are outside the guaranteed behaviour in decimal mode.

The unit has no clock and no state. It is meant to sit in an execution stage between operand fetch and the flag and result write-back.

Top module: `addsub_bcd`

## Requirements
- R1: With `dec_mode`=0 and `op_sub`=0, {`carry_out`,`result`} equals `op_a` + `op_b` + `carry_in` as a 9-bit unsigned sum.
- R2: With `dec_mode`=0 and `op_sub`=1, `result` equals (`op_a` − `op_b` − (1−`carry_in`)) mod 256. `carry_out` is 1 exactly when that difference, taken as an integer, is not negative.
- R3: With `dec_mode`=1, `op_sub`=0 and both operands valid packed BCD (every nibble 0..9, low nibble the units digit), `result` is the packed BCD of (A + B + `carry_in`) mod 100. `carry_out` is 1 exactly when that sum is 100 or more.
- R4: With `dec_mode`=1, `op_sub`=1 and valid BCD operands, `result` is the packed BCD of (A − B − (1−`carry_in`)) mod 100. `carry_out` is 1 exactly when the difference is not negative.
- R5: In binary mode `flag_z` is 1 exactly when `result` is 0.
- R6: In binary mode `flag_n` equals bit 7 (the top bit) of `result`.
- R7: In binary mode `flag_v` is 1 exactly when the signed two's-complement result of the add or subtract, including the carry/borrow, falls outside −128..127.
- R8: `flags_valid` is 1 in binary mode and 0 in decimal mode. In decimal mode `flag_n`, `flag_v` and `flag_z` are all 0, whatever the operands.
- R9: In decimal mode with valid BCD operands, every nibble of `result` is in 0..9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | First operand (minuend for subtraction) |
| op_b | input | 8 | Second operand (subtrahend for subtraction) |
| carry_in | input | 1 | Carry in; for subtraction, 1 means no borrow |
| op_sub | input | 1 | 0 selects add with carry, 1 selects subtract with borrow |
| dec_mode | input | 1 | 0 binary arithmetic, 1 packed-decimal arithmetic |
| result | output | 8 | Sum or difference |
| carry_out | output | 1 | Carry from add; for subtraction, 1 means no borrow |
| flag_n | output | 1 | Sign of result (binary mode only) |
| flag_v | output | 1 | Signed overflow (binary mode only) |
| flag_z | output | 1 | Result is zero (binary mode only) |
| flags_valid | output | 1 | 1 when flag_n, flag_v and flag_z are meaningful |

## Verification
The unit holds no state, so a wrong internal carry, a missed digit correction or a wrong borrow shows up at `result` or `carry_out` in the same evaluation as the operands that cause it. A digit correction that fires at the wrong threshold only shows when a digit sum is exactly 10 or a digit difference crosses zero. For that reason every valid BCD operand pair is applied with both carry-in values in both operations. A mode mux that is stuck shows at once, either as decimal results in binary tests or as nonzero flags while `flags_valid` is low.

// File: rtl/addsub_bcd_pkg.sv
package addsub_bcd_pkg;
    typedef enum logic {
        ARITH_ADD = 1'b0,
        ARITH_SUB = 1'b1
    } arith_op_e;

    localparam int unsigned NIBBLE_W = 4;
    localparam logic [NIBBLE_W-1:0] DIGIT_MAX = 4'd9;
    localparam logic [NIBBLE_W-1:0] DIGIT_ADJ = 4'd6;
endpackage

// File: rtl/addsub_bin_path.sv
module addsub_bin_path #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0]        a_i,
    input  logic [WIDTH-1:0]        b_i,
    input  logic                    cin_i,
    input  addsub_bcd_pkg::arith_op_e op_i,
    output logic [WIDTH-1:0]        sum_o,
    output logic                    cout_o,
    output logic                    ovf_o
);
    import addsub_bcd_pkg::*;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide_sum;

    always_comb begin
        b_eff    = (op_i == ARITH_SUB) ? ~b_i : b_i;
        wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
        sum_o    = wide_sum[WIDTH-1:0];
        cout_o   = wide_sum[WIDTH];
        ovf_o    = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
    end
endmodule

// File: rtl/addsub_bcd_digit.sv
module addsub_bcd_digit (
    input  logic [3:0]                a_i,
    input  logic [3:0]                b_i,
    input  logic                      cin_i,
    input  addsub_bcd_pkg::arith_op_e op_i,
    output logic [3:0]                d_o,
    output logic                      cout_o
);
    import addsub_bcd_pkg::*;

    logic [4:0] raw;

    always_comb begin
        if (op_i == ARITH_ADD) begin
            raw = {1'b0, a_i} + {1'b0, b_i} + {4'b0000, cin_i};
            if (raw > {1'b0, DIGIT_MAX}) begin
                d_o    = raw[3:0] + DIGIT_ADJ;
                cout_o = 1'b1;
            end else begin
                d_o    = raw[3:0];
                cout_o = 1'b0;
            end
        end else begin
            raw = {1'b0, a_i} - {1'b0, b_i} - {4'b0000, ~cin_i};
            if (raw[4]) begin
                d_o    = raw[3:0] - DIGIT_ADJ;
                cout_o = 1'b0;
            end else begin
                d_o    = raw[3:0];
                cout_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/addsub_dec_path.sv
module addsub_dec_path #(
    parameter int unsigned DIGITS = 2
) (
    input  logic [4*DIGITS-1:0]       a_i,
    input  logic [4*DIGITS-1:0]       b_i,
    input  logic                      cin_i,
    input  addsub_bcd_pkg::arith_op_e op_i,
    output logic [4*DIGITS-1:0]       sum_o,
    output logic                      cout_o
);
    import addsub_bcd_pkg::*;

    logic [DIGITS:0] chain;

    assign chain[0] = cin_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        addsub_bcd_digit u_digit (
            .a_i    (a_i[4*g +: 4]),
            .b_i    (b_i[4*g +: 4]),
            .cin_i  (chain[g]),
            .op_i   (op_i),
            .d_o    (sum_o[4*g +: 4]),
            .cout_o (chain[g+1])
        );

        always_comb begin
            if (a_i[4*g +: 4] <= DIGIT_MAX && b_i[4*g +: 4] <= DIGIT_MAX) begin
                p_digit_in_range_r9: assert (sum_o[4*g +: 4] <= DIGIT_MAX)
                    else $error("decimal digit %0d out of range", g);
            end
        end
    end

    assign cout_o = chain[DIGITS];
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] res_i,
    input  logic             ovf_i,
    input  logic             dec_i,
    output logic             n_o,
    output logic             v_o,
    output logic             z_o,
    output logic             valid_o
);
    always_comb begin
        valid_o = ~dec_i;
        n_o     = valid_o & res_i[WIDTH-1];
        v_o     = valid_o & ovf_i;
        z_o     = valid_o & (res_i == '0);
    end
endmodule

// File: rtl/addsub_bcd.sv
module addsub_bcd #(
    parameter int unsigned DIGITS = 2
) (
    input  logic [4*DIGITS-1:0] op_a,
    input  logic [4*DIGITS-1:0] op_b,
    input  logic                carry_in,
    input  logic                op_sub,
    input  logic                dec_mode,
    output logic [4*DIGITS-1:0] result,
    output logic                carry_out,
    output logic                flag_n,
    output logic                flag_v,
    output logic                flag_z,
    output logic                flags_valid
);
    import addsub_bcd_pkg::*;

    localparam int unsigned WIDTH = 4 * DIGITS;

    arith_op_e        op_sel;
    logic [WIDTH-1:0] bin_sum;
    logic [WIDTH-1:0] dec_sum;
    logic             bin_cout;
    logic             dec_cout;
    logic             bin_ovf;

    assign op_sel = arith_op_e'(op_sub);

    addsub_bin_path #(.WIDTH(WIDTH)) u_bin (
        .a_i    (op_a),
        .b_i    (op_b),
        .cin_i  (carry_in),
        .op_i   (op_sel),
        .sum_o  (bin_sum),
        .cout_o (bin_cout),
        .ovf_o  (bin_ovf)
    );

    addsub_dec_path #(.DIGITS(DIGITS)) u_dec (
        .a_i    (op_a),
        .b_i    (op_b),
        .cin_i  (carry_in),
        .op_i   (op_sel),
        .sum_o  (dec_sum),
        .cout_o (dec_cout)
    );

    assign result    = dec_mode ? dec_sum  : bin_sum;
    assign carry_out = dec_mode ? dec_cout : bin_cout;

    addsub_flags #(.WIDTH(WIDTH)) u_flags (
        .res_i   (result),
        .ovf_i   (bin_ovf),
        .dec_i   (dec_mode),
        .n_o     (flag_n),
        .v_o     (flag_v),
        .z_o     (flag_z),
        .valid_o (flags_valid)
    );

    always_comb begin
        if (!dec_mode && !op_sub) begin
            p_bin_add_r1: assert ({carry_out, result} ==
                                  ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
                else $error("binary add mismatch");
        end
        if (!dec_mode) begin
            p_zero_r5: assert (flag_z == (result == '0))
                else $error("zero flag mismatch");
            p_sign_r6: assert (flag_n == result[WIDTH-1])
                else $error("sign flag mismatch");
            p_valid_bin_r8: assert (flags_valid)
                else $error("flags not valid in binary mode");
        end else begin
            p_dec_flags_r8: assert (!flags_valid && !flag_n && !flag_v && !flag_z)
                else $error("flags active in decimal mode");
        end
        if (!dec_mode && !op_sub && op_a[WIDTH-1] != op_b[WIDTH-1]) begin
            p_no_mixed_ovf_r7: assert (!flag_v)
                else $error("overflow on mixed-sign add");
        end
    end
endmodule

// File: tb/addsub_bcd_bench.sv
module addsub_bcd_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic       carry_in = 1'b0;
    logic       op_sub = 1'b0;
    logic       dec_mode = 1'b0;
    logic [7:0] result;
    logic       carry_out, flag_n, flag_v, flag_z, flags_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addsub_bcd u_addsub_bcd (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .op_sub(op_sub),
        .dec_mode(dec_mode), .result(result), .carry_out(carry_out),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flags_valid(flags_valid)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s a=%02h b=%02h cin=%0d sub=%0d dec=%0d actual=%0h expected=%0h",
                     req, op_a, op_b, carry_in, op_sub, dec_mode, got, exp);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic s, input logic d);
        @(posedge clk);
        op_a = a; op_b = b; carry_in = c; op_sub = s; dec_mode = d;
        @(negedge clk);
    endtask

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    task automatic check_binary(input logic [7:0] a, input logic [7:0] b,
                                input logic c, input logic s);
        int ua, ub, sa, sb, br, uval, sval;
        apply(a, b, c, s, 1'b0);
        ua = int'(a); ub = int'(b);
        sa = (ua > 127) ? ua - 256 : ua;
        sb = (ub > 127) ? ub - 256 : ub;
        br = c ? 0 : 1;
        if (!s) begin
            uval = ua + ub + int'(c);
            sval = sa + sb + int'(c);
            check("R1 result", int'(result), uval % 256);
            check("R1 carry", int'(carry_out), (uval > 255) ? 1 : 0);
        end else begin
            uval = ua - ub - br;
            sval = sa - sb - br;
            check("R2 result", int'(result), (uval + 256) % 256);
            check("R2 carry", int'(carry_out), (uval >= 0) ? 1 : 0);
        end
        check("R5 zero", int'(flag_z), (((uval + 512) % 256) == 0) ? 1 : 0);
        check("R6 sign", int'(flag_n), (((uval + 512) % 256) >= 128) ? 1 : 0);
        check("R7 overflow", int'(flag_v), (sval < -128 || sval > 127) ? 1 : 0);
        check("R8 valid binary", int'(flags_valid), 1);
    endtask

    task automatic check_decimal(input int da, input int db,
                                 input logic c, input logic s);
        int v;
        apply(8'(to_bcd(da)), 8'(to_bcd(db)), c, s, 1'b1);
        if (!s) begin
            v = da + db + int'(c);
            check("R3 result", int'(result), to_bcd(v % 100));
            check("R3 carry", int'(carry_out), (v >= 100) ? 1 : 0);
        end else begin
            v = da - db - (c ? 0 : 1);
            check("R4 result", int'(result), to_bcd((v + 100) % 100));
            check("R4 carry", int'(carry_out), (v >= 0) ? 1 : 0);
        end
        check("R9 low digit", (int'(result[3:0]) <= 9) ? 1 : 0, 1);
        check("R9 high digit", (int'(result[7:4]) <= 9) ? 1 : 0, 1);
        check("R8 flags decimal", int'({flags_valid, flag_n, flag_v, flag_z}), 0);
    endtask

    task automatic t_idle_outputs;
        apply(8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R1 idle result", int'(result), 0);
        check("R5 idle zero", int'(flag_z), 1);
        check("R8 idle valid", int'(flags_valid), 1);
    endtask

    task automatic t_binary_corners;
        check_binary(8'hFF, 8'h00, 1'b1, 1'b0);
        check_binary(8'h7F, 8'h01, 1'b0, 1'b0);
        check_binary(8'h80, 8'h80, 1'b0, 1'b0);
        check_binary(8'h80, 8'h01, 1'b1, 1'b1);
        check_binary(8'h00, 8'h00, 1'b0, 1'b1);
        check_binary(8'h05, 8'h05, 1'b1, 1'b1);
        check_binary(8'h7F, 8'hFF, 1'b1, 1'b1);
    endtask

    task automatic t_binary_random;
        for (int i = 0; i < 3000; i++) begin
            check_binary(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    task automatic t_decimal_corners;
        check_decimal(99, 0, 1'b1, 1'b0);
        check_decimal(0, 1, 1'b1, 1'b1);
        check_decimal(0, 0, 1'b0, 1'b1);
        check_decimal(45, 55, 1'b0, 1'b0);
        check_decimal(50, 50, 1'b1, 1'b1);
    endtask

    task automatic t_decimal_exhaustive;
        for (int a = 0; a < 100; a++) begin
            for (int b = 0; b < 100; b++) begin
                for (int m = 0; m < 4; m++) begin
                    check_decimal(a, b, m[0], m[1]);
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_idle_outputs();
        t_binary_corners();
        t_binary_random();
        t_decimal_corners();
        t_decimal_exhaustive();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule